// File: doc/BRIEF.md
# Two-Road Priority Traffic Light Controller

This block controls the signals at a junction where a busy highway crosses a quiet farm road. The highway holds green by default. The farm road is served only when its car sensor reports a waiting vehicle, and only after the highway has had a minimum green time. Each road gets a fixed amber interval before it turns red.

The controller has two cooperating parts. A four-phase sequencer chooses the colours. A separate interval timer counts clock cycles since its last restart and raises a short flag and a long flag. The sequencer restarts the timer on every phase change. Every phase transition is qualified only by those two flags and the sensor, so the sequencer logic does not depend on the clock period. Interval lengths are parameters given in clock cycles. The lamp codes come from registers, so they do not glitch.

Top module: `tlc_junction`

## Requirements
- R1: While reset is asserted, and until the first phase change after release, the highway lamp shows green (10) and the farm lamp shows red (00).
- R2: In the highway-green phase the controller moves to highway amber on a clock edge only if the sensor is high and at least LONG_CYCLES cycles have passed since the phase began. Otherwise it stays in highway green.
- R3: Highway amber (highway 01, farm 00) lasts exactly SHORT_CYCLES+1 cycles and is then followed by farm green.
- R4: Farm green (highway 00, farm 10) ends on a clock edge where the sensor is low or at least LONG_CYCLES cycles have passed since the phase began. It is followed by farm amber.
- R5: Farm amber (highway 00, farm 01) lasts exactly SHORT_CYCLES+1 cycles and is then followed by highway green.
- R6: In every cycle at least one of the two lamps shows red (00).
- R7: The lamp encoding is 00 red, 01 amber, 10 green. Code 11 never appears on either lamp.
- R8: The interval timer restarts on every phase change. With the sensor held high, highway green and farm green therefore each last exactly LONG_CYCLES+1 cycles.
- R9: While the sensor stays low, the highway stays green for any number of cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| farm_car | input | 1 | High while cars wait on the farm road |
| hwy_lamp | output | 2 | Highway colour code (00 red, 01 amber, 10 green) |
| farm_lamp | output | 2 | Farm colour code (00 red, 01 amber, 10 green) |

## Verification
The embedded assertions check the following on every cycle:
- one lamp is always red and code 11 never appears;
- a phase change is always preceded by a timer restart;
- the long flag implies the short flag, and the flags hold until the next restart;
- highway amber never ends early;
- highway green is held while the sensor is low.

The exact length of each phase needs the bench's cycle-by-cycle reference model. So does an early farm-green exit when the sensor drops, and a sensor pulse that ends before the long interval and must cause no change.

// File: rtl/tlc_pkg.sv
package tlc_pkg;

  typedef enum logic [1:0] {
    PH_HWY_GO   = 2'b00,
    PH_HWY_WARN = 2'b01,
    PH_FARM_GO  = 2'b10,
    PH_FARM_WARN = 2'b11
  } phase_t;

  localparam logic [1:0] LAMP_RED   = 2'b00;
  localparam logic [1:0] LAMP_AMBER = 2'b01;
  localparam logic [1:0] LAMP_GREEN = 2'b10;

  typedef struct packed {
    logic [1:0] hwy;
    logic [1:0] farm;
  } lamps_t;

  function automatic lamps_t lamps_of(phase_t p);
    lamps_t l;
    case (p)
      PH_HWY_GO:    begin l.hwy = LAMP_GREEN; l.farm = LAMP_RED;   end
      PH_HWY_WARN:  begin l.hwy = LAMP_AMBER; l.farm = LAMP_RED;   end
      PH_FARM_GO:   begin l.hwy = LAMP_RED;   l.farm = LAMP_GREEN; end
      PH_FARM_WARN: begin l.hwy = LAMP_RED;   l.farm = LAMP_AMBER; end
      default:      begin l.hwy = LAMP_RED;   l.farm = LAMP_RED;   end
    endcase
    return l;
  endfunction

endpackage

// File: rtl/tlc_rst_sync.sv
module tlc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/tlc_timer.sv
module tlc_timer #(
  parameter int SHORT_CYCLES = 4,
  parameter int LONG_CYCLES  = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic short_done,
  output logic long_done
);
  localparam int CW = $clog2(LONG_CYCLES + 1);
  localparam logic [CW-1:0] SHORT_LIM = CW'(SHORT_CYCLES);
  localparam logic [CW-1:0] LONG_LIM  = CW'(LONG_CYCLES);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = restart || (cnt_q != LONG_LIM);
    cnt_d  = restart ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign short_done = (cnt_q >= SHORT_LIM);
  assign long_done  = (cnt_q >= LONG_LIM);

  p_long_implies_short_r8: assert property (@(posedge clk) disable iff (!rst_n)
    long_done |-> short_done);
  p_flag_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (short_done && !restart) |=> short_done);
  p_restart_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !long_done);
endmodule

// File: rtl/tlc_sequencer.sv
module tlc_sequencer
  import tlc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   car,
  input  logic   short_done,
  input  logic   long_done,
  output logic   restart,
  output phase_t phase_q,
  output phase_t phase_d
);
  always_comb begin
    case (phase_q)
      PH_HWY_GO:    phase_d = (car && long_done)  ? PH_HWY_WARN  : PH_HWY_GO;
      PH_HWY_WARN:  phase_d = short_done          ? PH_FARM_GO   : PH_HWY_WARN;
      PH_FARM_GO:   phase_d = (!car || long_done) ? PH_FARM_WARN : PH_FARM_GO;
      PH_FARM_WARN: phase_d = short_done          ? PH_HWY_GO    : PH_FARM_WARN;
      default:      phase_d = PH_HWY_GO;
    endcase
    restart = (phase_d != phase_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_HWY_GO;
    else        phase_q <= phase_d;
  end

  p_change_needs_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != $past(phase_q)) |-> $past(restart));
  p_hwy_warn_min_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_HWY_WARN && !short_done) |=> (phase_q == PH_HWY_WARN));
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_HWY_GO && !car) |=> (phase_q == PH_HWY_GO));
endmodule

// File: rtl/tlc_lamp_reg.sv
module tlc_lamp_reg
  import tlc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  phase_t     phase_next,
  output logic [1:0] hwy_lamp,
  output logic [1:0] farm_lamp
);
  lamps_t lamps_d, lamps_q;

  always_comb lamps_d = lamps_of(phase_next);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lamps_q.hwy  <= LAMP_GREEN;
      lamps_q.farm <= LAMP_RED;
    end else begin
      lamps_q <= lamps_d;
    end
  end

  assign hwy_lamp  = lamps_q.hwy;
  assign farm_lamp = lamps_q.farm;

  p_one_red_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hwy_lamp == LAMP_RED) || (farm_lamp == LAMP_RED));
  p_legal_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hwy_lamp != 2'b11) && (farm_lamp != 2'b11));
endmodule

// File: rtl/tlc_junction.sv
module tlc_junction
  import tlc_pkg::*;
#(
  parameter int SHORT_CYCLES = 4,
  parameter int LONG_CYCLES  = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       farm_car,
  output logic [1:0] hwy_lamp,
  output logic [1:0] farm_lamp
);
  logic   rst_n_int;
  logic   restart, short_done, long_done;
  phase_t phase_q, phase_d;

  tlc_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_int)
  );

  tlc_timer #(.SHORT_CYCLES(SHORT_CYCLES), .LONG_CYCLES(LONG_CYCLES)) u_tmr (
    .clk(clk), .rst_n(rst_n_int), .restart(restart),
    .short_done(short_done), .long_done(long_done)
  );

  tlc_sequencer u_seq (
    .clk(clk), .rst_n(rst_n_int), .car(farm_car),
    .short_done(short_done), .long_done(long_done),
    .restart(restart), .phase_q(phase_q), .phase_d(phase_d)
  );

  tlc_lamp_reg u_lamp (
    .clk(clk), .rst_n(rst_n_int), .phase_next(phase_d),
    .hwy_lamp(hwy_lamp), .farm_lamp(farm_lamp)
  );

  initial begin
    assert (SHORT_CYCLES >= 1 && SHORT_CYCLES < LONG_CYCLES)
      else $error("interval parameters out of order");
  end
endmodule

// File: tb/sim_tlc_junction.sv
module sim_tlc_junction;
  localparam int S = 3;
  localparam int L = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       farm_car = 1'b0;
  logic [1:0] hwy_lamp, farm_lamp;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  tlc_junction #(.SHORT_CYCLES(S), .LONG_CYCLES(L)) u0 (
    .clk(clk), .rst_n(rst_n), .farm_car(farm_car),
    .hwy_lamp(hwy_lamp), .farm_lamp(farm_lamp)
  );

  always #2 clk = ~clk;

  // behavioural reference: phase 0 hwy green, 1 hwy amber, 2 farm green, 3 farm amber
  int m_st = 0, m_cnt = 0, m_sync = 0;
  always @(posedge clk) begin
    int nxt;
    bit sh, lg;
    if (!rst_n) begin
      m_sync = 0; m_st = 0; m_cnt = 0;
    end else if (m_sync < 2) begin
      m_sync++; m_st = 0; m_cnt = 0;
    end else begin
      sh = (m_cnt >= S);
      lg = (m_cnt >= L);
      case (m_st)
        0: nxt = (farm_car && lg) ? 1 : 0;
        1: nxt = sh ? 2 : 1;
        2: nxt = (!farm_car || lg) ? 3 : 2;
        default: nxt = sh ? 0 : 3;
      endcase
      if (nxt != m_st) m_cnt = 0;
      else if (m_cnt < L) m_cnt++;
      m_st = nxt;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // run-length tracking of observed phases
  int run_len = 0;
  int prev_idx = -1;
  int last_len [4];
  function automatic int idx_of(logic [1:0] h, logic [1:0] f);
    if (h == 2'b10) return 0;
    if (h == 2'b01) return 1;
    if (f == 2'b10) return 2;
    return 3;
  endfunction

  bit cmp_on = 1'b0;
  always @(negedge clk) begin
    if (cmp_on) begin
      int eh, ef, id;
      string tg;
      eh = (m_st == 0) ? 2 : (m_st == 1) ? 1 : 0;
      ef = (m_st == 2) ? 2 : (m_st == 3) ? 1 : 0;
      case (m_st)
        0: tg = "R2 highway green";
        1: tg = "R3 highway amber";
        2: tg = "R4 farm green";
        default: tg = "R5 farm amber";
      endcase
      chk({tg, " hwy"}, hwy_lamp, eh);
      chk({tg, " farm"}, farm_lamp, ef);
      chk("R6 one road red", (hwy_lamp == 2'b00 || farm_lamp == 2'b00), 1);
      chk("R7 no code 11", (hwy_lamp != 2'b11 && farm_lamp != 2'b11), 1);
      id = idx_of(hwy_lamp, farm_lamp);
      if (id == prev_idx) run_len++;
      else begin
        if (prev_idx >= 0) last_len[prev_idx] = run_len;
        prev_idx = id;
        run_len = 1;
      end
    end
  end

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_farm_green();
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (farm_lamp == 2'b10) return;
    end
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int hold_ok;
    cycles(3);
    chk("R1 reset hwy", hwy_lamp, 2);
    chk("R1 reset farm", farm_lamp, 0);
    #1 rst_n = 1'b1;
    cmp_on = 1'b1;
    cycles(3);
    chk("R1 after release hwy", hwy_lamp, 2);
    chk("R1 after release farm", farm_lamp, 0);

    // idle: sensor low for a long time
    hold_ok = 1;
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      if (hwy_lamp != 2'b10) hold_ok = 0;
    end
    chk("R9 highway held green", hold_ok, 1);

    // sensor held high: full cycles
    #1 farm_car = 1'b1;
    cycles(70);
    chk("R3 highway amber length", last_len[1], S + 1);
    chk("R5 farm amber length", last_len[3], S + 1);
    chk("R8 farm green length", last_len[2], L + 1);
    chk("R8 highway green length", last_len[0], L + 1);

    // sensor drops during farm green
    wait_farm_green();
    cycles(1);
    #1 farm_car = 1'b0;
    cycles(S + 6);
    chk("R4 early farm exit", (last_len[2] < L + 1), 1);
    chk("R5 farm amber after early exit", last_len[3], S + 1);

    // short sensor pulse before the long interval: no change
    cycles(2);
    #1 farm_car = 1'b1;
    cycles(2);
    #1 farm_car = 1'b0;
    hold_ok = 1;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (hwy_lamp != 2'b10) hold_ok = 0;
    end
    chk("R2 pulse before long ignored", hold_ok, 1);

    // late sensor after saturation: leaves on next edge
    #1 farm_car = 1'b1;
    cycles(2);
    chk("R2 leaves after long", hwy_lamp, 1);
    #1 farm_car = 1'b0;
    cycles(40);

    // reset in mid-cycle
    #1 farm_car = 1'b1;
    cycles(L + 4);
    #1 rst_n = 1'b0;
    cycles(2);
    chk("R1 mid-run reset hwy", hwy_lamp, 2);
    chk("R1 mid-run reset farm", farm_lamp, 0);
    #1 rst_n = 1'b1;
    cycles(30);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule